// File: doc/BRIEF.md
# Indexed saturating doubling widening multiplier

This block is a SIMD datapath stage. It takes two packed source vectors whose length is a multiple of 128 bits, a one-bit element-size mode and a three-bit lane index. The vectors are handled in independent 128-bit segments. In each segment, the even-numbered narrow elements of the first source each feed one multiplier. All multipliers in a segment share one narrow element of the second source, which the index picks. The index picks the same position in every segment.

Each signed product is doubled, clamped to the signed range of a lane twice as wide, and packed into consecutive wide lanes of the result. The result is registered and qualified by a valid strobe one cycle after the operands are accepted. A sticky flag records that some lane was clamped, and a dedicated clear input resets that flag.

Top module: `idx_sat_dmul`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_valid`, `result` and `sat_flag` are all zero.
- R2: `out_valid` equals the previous cycle's `in_valid`. `result` is loaded only when `in_valid` is high and otherwise holds its value.
- R3: With `mode` = 0, 16-bit sources give 32-bit results. Result lane e is bits [32e+31:32e]. It is computed from the 16-bit source-A element at position 2e and the 16-bit source-B element at position 8*(e div 4) + idx, where idx is `lane_idx[2:0]`. Both elements are signed two's complement, and the lane holds 2·a·b, saturated.
- R4: With `mode` = 1, 32-bit sources give 64-bit results. Result lane e is bits [64e+63:64e]. It is computed from the 32-bit source-A element at position 2e and the 32-bit source-B element at position 4*(e div 2) + `lane_idx[1:0]`. Both elements are signed, and the lane holds 2·a·b, saturated.
- R5: A lane is clamped only when both of its operands equal the most negative narrow value. It then holds the most positive wide value (0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF). Every other operand pair gives the exact product.
- R6: With `mode` = 1, `lane_idx[2]` has no effect on the result.
- R7: `sat_flag` goes high together with `out_valid` after an accepted operation in which any lane was clamped. It then stays high until it is cleared.
- R8: When `sat_clr` is high, `sat_flag` is zero on the next cycle. This holds even if a clamping operation is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are accepted this cycle |
| mode | input | 1 | 0: 16-bit to 32-bit lanes, 1: 32-bit to 64-bit lanes |
| lane_idx | input | 3 | Source-B element index within each 128-bit segment |
| src_a | input | VL_BITS | First source vector |
| src_b | input | VL_BITS | Second source vector |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result register was loaded on the previous accepted cycle |
| result | output | VL_BITS | Packed wide results |
| sat_flag | output | 1 | Sticky: some lane was clamped |

## Verification
The bench puts the most negative value on both operands of chosen lanes in both modes. A design that skips the clamp shows the most negative wide value in those lanes. It also puts that value against -1 and against the maximum. A design that clamps too eagerly corrupts those exact products.

The bench gives each segment a different broadcast element and sweeps the index. This exposes a design that reuses segment 0's element everywhere or that picks odd source-A elements.

In 32-bit mode the bench sets index bit 2. A design that does not mask the index then reads an element from the neighbouring segment.

Clear is raised in the same cycle as a clamping operation. A design that gives set priority over clear leaves the flag high.

// File: rtl/idsm_pkg.sv
package idsm_pkg;
   localparam int SEG_BITS = 128;
   localparam int NUM_VARIANTS = 2;
   localparam int BASE_NARROW = 16;

   typedef enum logic {
      MODE_H2W = 1'b0,
      MODE_W2D = 1'b1
   } elem_mode_e;

   function automatic int narrow_width(input int variant);
      return BASE_NARROW << variant;
   endfunction
endpackage

// File: rtl/idsm_lane_mul.sv
module idsm_lane_mul #(
   parameter int NW = 16
) (
   input  logic signed [NW-1:0]   opnd_a,
   input  logic signed [NW-1:0]   opnd_b,
   output logic        [2*NW-1:0] lane_out,
   output logic                   lane_sat
);
   localparam int WW = 2 * NW;

   logic signed [WW-1:0] prod;
   logic        [WW:0]   dbl;
   logic                 ovf;

   always_comb begin
      prod = opnd_a * opnd_b;
      dbl  = {prod, 1'b0};
      ovf  = dbl[WW] ^ dbl[WW-1];
      if (ovf) begin
         lane_out = dbl[WW] ? {1'b1, {(WW-1){1'b0}}} : {1'b0, {(WW-1){1'b1}}};
      end else begin
         lane_out = dbl[WW-1:0];
      end
   end

   assign lane_sat = ovf;
endmodule

// File: rtl/idsm_segment.sv
module idsm_segment
   import idsm_pkg::*;
(
   input  logic                mode,
   input  logic [2:0]          lane_idx,
   input  logic [SEG_BITS-1:0] seg_a,
   input  logic [SEG_BITS-1:0] seg_b,
   output logic [SEG_BITS-1:0] seg_res,
   output logic                seg_sat
);
   logic [SEG_BITS-1:0] var_res [NUM_VARIANTS];
   logic                var_sat [NUM_VARIANTS];

   for (genvar k = 0; k < NUM_VARIANTS; k++) begin : g_var
      localparam int NW     = narrow_width(k);
      localparam int WW     = 2 * NW;
      localparam int NNAR   = SEG_BITS / NW;
      localparam int NLANES = SEG_BITS / WW;
      localparam int IDXW   = $clog2(NNAR);

      logic [IDXW-1:0]   idx_m;
      logic [NW-1:0]     bcast;
      logic [NLANES-1:0] lane_sat_v;

      assign idx_m = lane_idx[IDXW-1:0];
      assign bcast = seg_b[idx_m*NW +: NW];

      for (genvar j = 0; j < NLANES; j++) begin : g_lane
         idsm_lane_mul #(.NW(NW)) u_mul (
            .opnd_a   (seg_a[2*j*NW +: NW]),
            .opnd_b   (bcast),
            .lane_out (var_res[k][j*WW +: WW]),
            .lane_sat (lane_sat_v[j])
         );
      end

      assign var_sat[k] = |lane_sat_v;
   end

   always_comb begin
      if (elem_mode_e'(mode) == MODE_W2D) begin
         seg_res = var_res[1];
         seg_sat = var_sat[1];
      end else begin
         seg_res = var_res[0];
         seg_sat = var_sat[0];
      end
   end

   logic unused_odd;
   assign unused_odd = ^{seg_a[63:48], seg_a[127:112], lane_idx[2]};
endmodule

// File: rtl/idx_sat_dmul.sv
module idx_sat_dmul
   import idsm_pkg::*;
#(
   parameter int VL_BITS = 256
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic               mode,
   input  logic [2:0]         lane_idx,
   input  logic [VL_BITS-1:0] src_a,
   input  logic [VL_BITS-1:0] src_b,
   input  logic               sat_clr,
   output logic               out_valid,
   output logic [VL_BITS-1:0] result,
   output logic               sat_flag
);
   localparam int NSEG = VL_BITS / SEG_BITS;

   if (VL_BITS < SEG_BITS || (VL_BITS % SEG_BITS) != 0) begin : g_bad_vl
      $error("VL_BITS must be a non-zero multiple of the segment width");
   end

   logic [VL_BITS-1:0] comb_res;
   logic [NSEG-1:0]    seg_sat_v;
   logic               any_sat;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      idsm_segment u_seg (
         .mode     (mode),
         .lane_idx (lane_idx),
         .seg_a    (src_a[s*SEG_BITS +: SEG_BITS]),
         .seg_b    (src_b[s*SEG_BITS +: SEG_BITS]),
         .seg_res  (comb_res[s*SEG_BITS +: SEG_BITS]),
         .seg_sat  (seg_sat_v[s])
      );
   end

   assign any_sat = |seg_sat_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= comb_res;
         end
         if (sat_clr) begin
            sat_flag <= 1'b0;
         end else if (in_valid && any_sat) begin
            sat_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/idsm_checker.sv
module idsm_checker #(
   parameter int VL_BITS = 256
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic               sat_clr,
   input logic               out_valid,
   input logic [VL_BITS-1:0] result,
   input logic               sat_flag
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && !sat_flag && result == '0));

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_result_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (sat_flag && !sat_clr) |=> sat_flag);

   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
      sat_clr |=> !sat_flag);

   assert_flag_rise_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(sat_flag) |-> out_valid);
endmodule

bind idx_sat_dmul idsm_checker #(.VL_BITS(VL_BITS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .sat_clr   (sat_clr),
   .out_valid (out_valid),
   .result    (result),
   .sat_flag  (sat_flag)
);

// File: tb/idx_sat_dmul_tb.sv
`timescale 1ns/1ps
module idx_sat_dmul_tb;
   localparam int VL = 256;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          mode = 1'b0;
   logic [2:0]    lane_idx = '0;
   logic [VL-1:0] src_a = '0;
   logic [VL-1:0] src_b = '0;
   logic          sat_clr = 1'b0;
   logic          out_valid;
   logic [VL-1:0] result;
   logic          sat_flag;

   int checks = 0;
   int errors = 0;

   logic          exp_valid = 1'b0;
   logic [VL-1:0] exp_res = '0;
   logic          exp_flag = 1'b0;

   always #2 clk = ~clk;

   idx_sat_dmul #(.VL_BITS(VL)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
      .lane_idx(lane_idx), .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
      .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
   );

   // returns {clamped, packed result}
   function automatic logic [VL:0] ref_op(input logic md, input logic [2:0] ix,
                                          input logic [VL-1:0] a, input logic [VL-1:0] b);
      logic [VL-1:0] r = '0;
      logic sat = 1'b0;
      if (!md) begin
         for (int e = 0; e < VL/32; e++) begin
            logic signed [15:0]  va = a[(2*e)*16 +: 16];
            logic signed [15:0]  vb = b[((e/4)*8 + int'(ix))*16 +: 16];
            logic signed [127:0] p  = 128'sd2 * va * vb;
            if (p > 128'sh7FFFFFFF) begin
               p = 128'sh7FFFFFFF; sat = 1'b1;
            end
            r[e*32 +: 32] = p[31:0];
         end
      end else begin
         for (int e = 0; e < VL/64; e++) begin
            logic signed [31:0]  va = a[(2*e)*32 +: 32];
            logic signed [31:0]  vb = b[((e/2)*4 + int'(ix[1:0]))*32 +: 32];
            logic signed [127:0] p  = 128'sd2 * va * vb;
            if (p > 128'sh7FFFFFFFFFFFFFFF) begin
               p = 128'sh7FFFFFFFFFFFFFFF; sat = 1'b1;
            end
            r[e*64 +: 64] = p[63:0];
         end
      end
      return {sat, r};
   endfunction

   function automatic logic [VL-1:0] rnd_vec();
      logic [VL-1:0] v;
      for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic step(input logic r, input logic iv, input logic md, input logic [2:0] ix,
                       input logic [VL-1:0] a, input logic [VL-1:0] b, input logic clr,
                       input string tag);
      logic [VL:0] ro;
      @(negedge clk);
      rst = r; in_valid = iv; mode = md; lane_idx = ix; src_a = a; src_b = b; sat_clr = clr;
      ro = ref_op(md, ix, a, b);
      if (r) begin
         exp_valid = 1'b0; exp_res = '0; exp_flag = 1'b0;
      end else begin
         exp_valid = iv;
         if (iv) exp_res = ro[VL-1:0];
         if (clr) exp_flag = 1'b0;
         else if (iv && ro[VL]) exp_flag = 1'b1;
      end
      @(posedge clk);
      #1;
      checks++;
      if (out_valid !== exp_valid) begin
         errors++;
         $display("FAIL %s: out_valid got %0b exp %0b", tag, out_valid, exp_valid);
      end
      checks++;
      if (result !== exp_res) begin
         errors++;
         $display("FAIL %s: result got %h exp %h", tag, result, exp_res);
      end
      checks++;
      if (sat_flag !== exp_flag) begin
         errors++;
         $display("FAIL %s: sat_flag got %0b exp %0b", tag, sat_flag, exp_flag);
      end
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [VL-1:0] a, b;
      // R1 reset state
      for (int i = 0; i < 3; i++) step(1, 1, 0, 3'd0, rnd_vec(), rnd_vec(), 0, "R1");
      step(0, 0, 0, 3'd0, '0, '0, 0, "R1_release");

      // R3: 16-bit mode, all indices, random operands
      for (int ix = 0; ix < 8; ix++) begin
         a = rnd_vec(); b = rnd_vec();
         a[15:0] = 16'h7FFF; b[15:0] = 16'h7FFF;
         step(0, 1, 0, 3'(ix), a, b, 0, "R3");
      end
      // R2: idle cycles hold result
      step(0, 0, 0, 3'd5, rnd_vec(), rnd_vec(), 0, "R2_hold");
      step(0, 0, 1, 3'd2, rnd_vec(), rnd_vec(), 0, "R2_hold");

      // R4: 32-bit mode, indices 0..3
      for (int ix = 0; ix < 4; ix++) step(0, 1, 1, 3'(ix), rnd_vec(), rnd_vec(), 0, "R4");
      // R6: index bit 2 ignored in 32-bit mode
      for (int ix = 4; ix < 8; ix++) step(0, 1, 1, 3'(ix), rnd_vec(), rnd_vec(), 0, "R6");

      // R5: near-extreme operands that must not clamp
      a = {16{16'h8000}}; b = {16{16'hFFFF}};
      step(0, 1, 0, 3'd3, a, b, 0, "R5_min_x_m1");
      b = {16{16'h7FFF}};
      step(0, 1, 0, 3'd6, a, b, 0, "R5_min_x_max");
      a = {8{32'h80000000}}; b = {8{32'h7FFFFFFF}};
      step(0, 1, 1, 3'd1, a, b, 0, "R5_min_x_max_w");

      // R5/R7: clamp in segment 0 only, 16-bit mode
      a = {16{16'h8000}}; b = '0;
      b[2*16 +: 16] = 16'h8000; b[128 + 2*16 +: 16] = 16'h8001;
      step(0, 1, 0, 3'd2, a, b, 0, "R5_R7_clamp_h");
      step(0, 0, 0, 3'd0, '0, '0, 0, "R7_sticky");
      // R8 clear
      step(0, 0, 0, 3'd0, '0, '0, 1, "R8_clear");
      // R5/R7: clamp in segment 1 only, 32-bit mode
      a = {8{32'h80000000}}; b = '0;
      b[128 + 3*32 +: 32] = 32'h80000000;
      step(0, 1, 1, 3'd7, a, b, 0, "R5_R7_clamp_w");
      step(0, 1, 0, 3'd1, rnd_vec(), rnd_vec() & {16{16'h7FFF}}, 0, "R7_sticky");
      // R8: clear beats same-cycle set
      step(0, 1, 1, 3'd7, a, b, 1, "R8_clear_priority");
      step(0, 0, 0, 3'd0, '0, '0, 0, "R8_after");

      // mixed random traffic
      for (int i = 0; i < 40; i++)
         step(0, 1'($urandom), 1'($urandom), 3'($urandom), rnd_vec(), rnd_vec(),
              ($urandom % 8) == 0, "R3_R4_mix");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule